// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one 14-bit successive-approximation conversion from start to finish. A command decoder upstream announces a start bit and hands over three decoded fields: input polarity, which clock drives the conversion, and frame length. The block then counts falling serial-clock edges through the acquisition window and drives the track/hold control. It steps a binary search over the DAC code against an external comparator and streams the result out MSB first. The analog DAC and comparator sit outside; `dac_code_o` feeds the DAC and `cmp_i` returns the comparison.

With the external clock, each falling serial-clock edge advances one step. The strobe marks the edge before the MSB with a one-period high pulse, and the frame ends with zero fill. With the internal clock, a local oscillator tick drives the search. The strobe is low while the conversion runs and high once it is done, and the serial clock then reads the stored word out. The serial clock arrives as one-cycle event pulses in the system clock domain. An abort from the command receiver or the active-low shutdown sends the sequencer back to idle at once.

Top module: `sarseq_top`

## Requirements
- R1: After reset the block is idle and configured for internal clock, short frame and bipolar input. `sample_o` is 0, `strobe_o` is 1 and driven, `dout_o` is 0 and `dac_code_o` is 0.
- R2: `sample_o` goes high with `start_i` and stays high until the falling serial edge that ends acquisition. That is the 6th counted fall in the short frame and the 14th in the long frame. `dout_o` stays 0 through acquisition.
- R3: With the external clock, `strobe_o` is high from the 7th counted fall to the 8th in the short frame, and from the 15th to the 16th in the long frame. Result bit 13 appears on `dout_o` at the fall that ends the pulse.
- R4: Bit 13 is tried first by setting it in `dac_code_o`, at the fall that raises the strobe or starts the internal conversion. Each later decision keeps the trial bit when `cmp_i` is 1 (input at or above the code) and clears it otherwise, then sets the next lower bit.
- R5: With `cmd_unipolar_i` = 1 the result is straight binary. With `cmd_unipolar_i` = 0 bit 13 of the result is inverted, which gives two's complement.
- R6: With the external clock, the 14 result bits occupy 14 consecutive falls. `dout_o` is 0 for the rest of the 24-fall (short) or 32-fall (long) frame. After the last fall the block is idle with `dac_code_o` = 0.
- R7: With the internal clock, `strobe_o` drops at the fall that ends the lead (7th short, 15th long). Each `osc_tick_i` decides one bit. After the 14th tick `strobe_o` is 1 and `dout_o` holds bit 13. Each later fall presents the next bit, and zeros follow bit 0.
- R8: `dout_oe_o` is high only while `cs_n_i` is low. `strobe_oe_o` follows the same rule with the external clock, and it stays high with the internal clock.
- R9: A serial fall while `cs_n_i` is high has no effect on the count, the code or `dout_o`. The sequence resumes when `cs_n_i` returns low.
- R10: `abort_i` high, or `shdn_n_i` low, returns the block to idle in the next cycle. At that point `sample_o` = 0, `dout_o` = 0 and `dac_code_o` = 0, and the strobe is back at its idle level (1 with the internal clock, 0 with the external one). No partial result is ever shifted out.
- R11: A `start_i` at any point restarts acquisition with the new command fields. Nothing is kept from the sequence it cut off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_fall_i | input | 1 | One-cycle pulse per falling serial-clock edge |
| osc_tick_i | input | 1 | Internal conversion oscillator tick |
| cs_n_i | input | 1 | Chip select, active low |
| start_i | input | 1 | Start bit recognised by the command receiver |
| cmd_unipolar_i | input | 1 | 1 = unipolar, 0 = bipolar (sampled with start_i) |
| cmd_intclk_i | input | 1 | 1 = internal conversion clock (sampled with start_i) |
| cmd_long_i | input | 1 | 1 = 32-clock frame, 0 = 24-clock frame |
| abort_i | input | 1 | Abort request from the receiver |
| shdn_n_i | input | 1 | Shutdown, active low |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC code |
| dac_code_o | output | 14 | Trial code for the DAC |
| sample_o | output | 1 | Track (1) / hold (0) control |
| strobe_o | output | 1 | Serial strobe value |
| strobe_oe_o | output | 1 | Strobe output enable |
| dout_o | output | 1 | Serial data out value |
| dout_oe_o | output | 1 | Serial data out enable |

## Verification
The stop paths and the step paths can land on the same clock cycle. An abort or shutdown can arrive in the same cycle as an oscillator tick during an internal conversion, or as a new start. The bench aborts an internal conversion partway through its ticks, and it cuts an external frame short with shutdown. It then clocks more serial edges and judges that the strobe sits at its idle level and that `dout_o` and the DAC code stay at zero. A restart in the middle of acquisition has to produce a fully correct frame for the second command.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACQ   = 3'd1,
        ST_XCONV = 3'd2,
        ST_ICONV = 3'd3,
        ST_IREAD = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic unipolar;
        logic intclk;
        logic long_acq;
    } seq_cmd_t;

    localparam seq_cmd_t CMD_RESET = '{unipolar: 1'b0, intclk: 1'b1, long_acq: 1'b0};

    function automatic int unsigned span_pick(input logic lng, input int unsigned base,
                                              input int unsigned extra);
        return lng ? base + extra : base;
    endfunction

    function automatic logic msb_fix(input logic msb, input logic unipolar);
        return unipolar ? msb : ~msb;
    endfunction

endpackage

// File: rtl/sarseq_search.sv
module sarseq_search #(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_i,
    input  logic           init_i,
    input  logic           step_i,
    input  logic           cmp_i,
    output logic [RES-1:0] code_o,
    output logic [RES-1:0] next_code_o,
    output logic           active_o,
    output logic           first_o,
    output logic           last_o
);
    localparam logic [RES-1:0] TOP_BIT = {1'b1, {(RES-1){1'b0}}};

    logic [RES-1:0] code_q;
    logic [RES-1:0] mask_q;

    always_comb begin
        next_code_o = (cmp_i ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (init_i) begin
            code_q <= TOP_BIT;
            mask_q <= TOP_BIT;
        end else if (step_i && (mask_q != '0)) begin
            code_q <= next_code_o;
            mask_q <= mask_q >> 1;
        end
    end

    assign code_o   = code_q;
    assign active_o = (mask_q != '0);
    assign first_o  = mask_q[RES-1];
    assign last_o   = mask_q[0];
endmodule

// File: rtl/sarseq_unload.sv
module sarseq_unload #(
    parameter int RES = 14
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [RES-1:0] word_i,
    input  logic           shift_i,
    output logic           head_o
);
    logic [RES-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (load_i) begin
            hold_q <= word_i << 1;
        end else if (shift_i) begin
            hold_q <= hold_q << 1;
        end
    end

    assign head_o = hold_q[RES-1];
endmodule

// File: rtl/sarseq_top.sv
module sarseq_top
    import sarseq_pkg::*;
#(
    parameter int RES         = 14,
    parameter int LEAD_SHORT  = 7,
    parameter int LONG_EXTRA  = 8,
    parameter int FRAME_SHORT = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sclk_fall_i,
    input  logic           osc_tick_i,
    input  logic           cs_n_i,
    input  logic           start_i,
    input  logic           cmd_unipolar_i,
    input  logic           cmd_intclk_i,
    input  logic           cmd_long_i,
    input  logic           abort_i,
    input  logic           shdn_n_i,
    input  logic           cmp_i,
    output logic [RES-1:0] dac_code_o,
    output logic           sample_o,
    output logic           strobe_o,
    output logic           strobe_oe_o,
    output logic           dout_o,
    output logic           dout_oe_o
);
    localparam int FRAME_LONG = FRAME_SHORT + LONG_EXTRA;
    localparam int CNT_W      = $clog2(FRAME_LONG + 1);

    seq_state_e     state_q;
    seq_cmd_t       cmd_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] lead_sel;
    logic [CNT_W-1:0] frame_sel;
    logic           sample_q;
    logic           strobe_q;
    logic           dout_q;
    logic           mode_int_w;

    logic           ev;
    logic           kill;
    logic           live;

    logic           s_clr, s_init, s_step;
    logic [RES-1:0] s_code, s_next;
    logic           s_active, s_first, s_last;
    logic           u_load, u_shift, u_head;
    logic [RES-1:0] fin_word;

    assign ev         = sclk_fall_i && !cs_n_i;
    assign kill       = abort_i || !shdn_n_i;
    assign live       = !kill && !start_i;
    assign cnt_nx     = cnt_q + 1'b1;
    assign lead_sel   = CNT_W'(span_pick(cmd_q.long_acq, LEAD_SHORT, LONG_EXTRA));
    assign frame_sel  = CNT_W'(span_pick(cmd_q.long_acq, FRAME_SHORT, LONG_EXTRA));
    assign mode_int_w = cmd_q.intclk;

    assign fin_word = {msb_fix(s_next[RES-1], cmd_q.unipolar), s_next[RES-2:0]};

    always_comb begin
        s_clr   = kill || start_i || (state_q == ST_XCONV && ev && cnt_nx == frame_sel);
        s_init  = live && state_q == ST_ACQ && ev && cnt_nx == lead_sel;
        s_step  = live && s_active &&
                  ((state_q == ST_XCONV && ev) || (state_q == ST_ICONV && osc_tick_i));
        u_load  = live && state_q == ST_ICONV && osc_tick_i && s_last;
        u_shift = live && state_q == ST_IREAD && ev;
    end

    sarseq_search #(.RES(RES)) search_i (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (s_clr),
        .init_i     (s_init),
        .step_i     (s_step),
        .cmp_i      (cmp_i),
        .code_o     (s_code),
        .next_code_o(s_next),
        .active_o   (s_active),
        .first_o    (s_first),
        .last_o     (s_last)
    );

    sarseq_unload #(.RES(RES)) unload_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (u_load),
        .word_i (fin_word),
        .shift_i(u_shift),
        .head_o (u_head)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cmd_q    <= CMD_RESET;
            cnt_q    <= '0;
            sample_q <= 1'b0;
            strobe_q <= 1'b1;
            dout_q   <= 1'b0;
        end else if (kill) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sample_q <= 1'b0;
            strobe_q <= cmd_q.intclk;
            dout_q   <= 1'b0;
        end else if (start_i) begin
            state_q  <= ST_ACQ;
            cmd_q    <= '{unipolar: cmd_unipolar_i, intclk: cmd_intclk_i, long_acq: cmd_long_i};
            cnt_q    <= '0;
            sample_q <= 1'b1;
            strobe_q <= cmd_intclk_i;
            dout_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ACQ: begin
                    if (ev) begin
                        cnt_q <= cnt_nx;
                        if (cnt_nx == lead_sel - 1'b1) begin
                            sample_q <= 1'b0;
                        end
                        if (cnt_nx == lead_sel) begin
                            state_q  <= cmd_q.intclk ? ST_ICONV : ST_XCONV;
                            strobe_q <= !cmd_q.intclk;
                        end
                    end
                end
                ST_XCONV: begin
                    if (ev) begin
                        cnt_q    <= cnt_nx;
                        strobe_q <= 1'b0;
                        if (s_active) begin
                            dout_q <= s_first ? msb_fix(cmp_i, cmd_q.unipolar) : cmp_i;
                        end else begin
                            dout_q <= 1'b0;
                        end
                        if (cnt_nx == frame_sel) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_ICONV: begin
                    if (osc_tick_i && s_last) begin
                        state_q  <= ST_IREAD;
                        strobe_q <= 1'b1;
                        dout_q   <= fin_word[RES-1];
                    end
                end
                ST_IREAD: begin
                    if (ev) begin
                        dout_q <= u_head;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign dac_code_o  = s_code;
    assign sample_o    = sample_q;
    assign strobe_o    = strobe_q;
    assign strobe_oe_o = cmd_q.intclk || !cs_n_i;
    assign dout_o      = dout_q;
    assign dout_oe_o   = !cs_n_i;
endmodule

// File: rtl/sarseq_chk.sv
module sarseq_chk #(
    parameter int RES = 14
) (
    input logic           clk,
    input logic           rst,
    input logic           sclk_fall_i,
    input logic           osc_tick_i,
    input logic           cs_n_i,
    input logic           start_i,
    input logic           abort_i,
    input logic           shdn_n_i,
    input logic [RES-1:0] dac_code_o,
    input logic           sample_o,
    input logic           strobe_o,
    input logic           dout_o,
    input logic           mode_int
);
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (abort_i || !shdn_n_i) |=> (!sample_o && !dout_o && dac_code_o == '0));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_int && strobe_o && sclk_fall_i && !cs_n_i && !start_i && !abort_i && shdn_n_i)
        |=> !strobe_o);

    assert_cs_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (cs_n_i && !start_i && !abort_i && shdn_n_i && !osc_tick_i)
        |=> ($stable(dac_code_o) && $stable(dout_o)));

    assert_hold_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(sample_o) |-> ($past(sclk_fall_i && !cs_n_i) || $past(abort_i) || !$past(shdn_n_i)));

    assert_track_strobe_apart_R3: assert property (@(posedge clk) disable iff (rst)
        !(sample_o && strobe_o && !mode_int));
endmodule

bind sarseq_top sarseq_chk #(.RES(RES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .sclk_fall_i(sclk_fall_i),
    .osc_tick_i (osc_tick_i),
    .cs_n_i     (cs_n_i),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .shdn_n_i   (shdn_n_i),
    .dac_code_o (dac_code_o),
    .sample_o   (sample_o),
    .strobe_o   (strobe_o),
    .dout_o     (dout_o),
    .mode_int   (mode_int_w)
);

// File: tb/sarseq_tb.sv
module sarseq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RES = 14;

    typedef struct {
        logic  b;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk_fall = 1'b0, osc_tick = 1'b0, cs_n = 1'b0, start = 1'b0;
    logic c_uni = 1'b0, c_int = 1'b0, c_long = 1'b0, abort = 1'b0, shdn_n = 1'b1;
    logic cmp;
    logic [RES-1:0] dac_code;
    logic sample, strobe, strobe_oe, dout, dout_oe;
    logic [RES-1:0] vin = '0;

    int total = 0;
    int failed = 0;
    exp_t exp_q[$];
    logic pend = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp = (vin >= dac_code);

    sarseq_top dut_i (
        .clk(clk), .rst(rst), .sclk_fall_i(sclk_fall), .osc_tick_i(osc_tick),
        .cs_n_i(cs_n), .start_i(start), .cmd_unipolar_i(c_uni), .cmd_intclk_i(c_int),
        .cmd_long_i(c_long), .abort_i(abort), .shdn_n_i(shdn_n), .cmp_i(cmp),
        .dac_code_o(dac_code), .sample_o(sample), .strobe_o(strobe),
        .strobe_oe_o(strobe_oe), .dout_o(dout), .dout_oe_o(dout_oe)
    );

    task automatic check_eq(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // monitor: compares dout after every counted serial fall against the queue
    always @(posedge clk) pend <= sclk_fall && !cs_n && !rst;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check_eq("R6 scoreboard underflow", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check_eq(e.tag, int'(dout), int'(e.b));
            end
        end
    end

    task automatic do_fall(input logic e, input string tag);
        exp_t it;
        it.b = e;
        it.tag = tag;
        if (!cs_n) exp_q.push_back(it);
        @(negedge clk) sclk_fall = 1'b1;
        @(negedge clk) sclk_fall = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
    endtask

    task automatic send_start(input logic u, input logic i, input logic l);
        @(negedge clk);
        start = 1'b1; c_uni = u; c_int = i; c_long = l;
        @(negedge clk) start = 1'b0;
        check_eq("R2 sample after start", int'(sample), 1);
    endtask

    function automatic logic [RES-1:0] expect_word(input logic u, input logic [RES-1:0] v);
        return u ? v : (v ^ 14'h2000);
    endfunction

    task automatic ext_falls(input logic u, input logic l, input int from, input int upto);
        int lead, frame;
        logic [RES-1:0] w;
        lead = l ? 15 : 7;
        frame = l ? 32 : 24;
        w = expect_word(u, vin);
        for (int k = from; k <= upto; k++) begin
            logic e;
            string tg;
            if (k > lead && k <= lead + RES) begin
                e = w[RES - 1 - (k - lead - 1)];
                tg = (k == lead + 1) ? (u ? "R3 msb" : "R5 msb") : "R4 bit";
            end else begin
                e = 1'b0;
                tg = (k > lead) ? "R6 fill" : "R2 acq";
            end
            do_fall(e, tg);
            check_eq("R2 sample", int'(sample), int'(k < lead - 1));
            check_eq("R3 strobe", int'(strobe), int'(k == lead));
            if (k == lead) check_eq("R4 first trial", int'(dac_code), 'h2000);
            if (k == lead + 1)
                check_eq("R4 second trial", int'(dac_code), int'({vin[13], 13'h1000}));
            if (k == frame) check_eq("R6 idle code", int'(dac_code), 0);
        end
    endtask

    task automatic int_acq(input logic l);
        int lead;
        lead = l ? 15 : 7;
        for (int k = 1; k <= lead; k++) begin
            do_fall(1'b0, "R2 acq");
            check_eq("R7 strobe acq", int'(strobe), int'(k < lead));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check_eq("R1 watchdog", 1, 0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 sample", int'(sample), 0);
        check_eq("R1 strobe", int'(strobe), 1);
        check_eq("R1 strobe_oe", int'(strobe_oe), 1);
        check_eq("R1 dout", int'(dout), 0);
        check_eq("R1 dac", int'(dac_code), 0);

        // external short, unipolar
        vin = 14'h2A5C;
        send_start(1'b1, 1'b0, 1'b0);
        ext_falls(1'b1, 1'b0, 1, 24);

        // external short, bipolar
        vin = 14'h1234;
        send_start(1'b0, 1'b0, 1'b0);
        ext_falls(1'b0, 1'b0, 1, 24);

        // external long, bipolar, full-scale input
        vin = 14'h3FFF;
        send_start(1'b0, 1'b0, 1'b1);
        ext_falls(1'b0, 1'b1, 1, 32);

        // zero input, unipolar
        vin = 14'h0000;
        send_start(1'b1, 1'b0, 1'b0);
        ext_falls(1'b1, 1'b0, 1, 24);

        // R8 R9: chip select high mid-conversion
        vin = 14'h15A3;
        send_start(1'b1, 1'b0, 1'b0);
        ext_falls(1'b1, 1'b0, 1, 10);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        check_eq("R8 strobe_oe ext cs high", int'(strobe_oe), 0);
        check_eq("R8 dout_oe cs high", int'(dout_oe), 0);
        begin
            logic [RES-1:0] held;
            logic hd;
            held = dac_code;
            hd = dout;
            for (int i = 0; i < 3; i++) do_fall(1'b0, "R9");
            check_eq("R9 code held", int'(dac_code), int'(held));
            check_eq("R9 dout held", int'(dout), int'(hd));
        end
        @(negedge clk) cs_n = 1'b0;
        ext_falls(1'b1, 1'b0, 11, 24);

        // R7: internal clock conversion and readout
        vin = 14'h0F0F;
        send_start(1'b1, 1'b1, 1'b0);
        int_acq(1'b0);
        check_eq("R4 int first trial", int'(dac_code), 'h2000);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        check_eq("R8 strobe_oe int cs high", int'(strobe_oe), 1);
        for (int t = 1; t <= RES; t++) begin
            tick();
            check_eq("R7 strobe during conv", int'(strobe), int'(t == RES));
        end
        check_eq("R7 msb ready", int'(dout), int'(vin[13]));
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < 16; i++) do_fall(i < 13 ? vin[12 - i] : 1'b0, "R7 readout");

        // R7 R5: internal, long, bipolar
        vin = 14'h2001;
        send_start(1'b0, 1'b1, 1'b1);
        int_acq(1'b1);
        for (int t = 1; t <= RES; t++) tick();
        check_eq("R5 int msb", int'(dout), int'(expect_word(1'b0, vin) >> 13));
        for (int i = 0; i < 14; i++) do_fall(i < 13 ? vin[12 - i] : 1'b0, "R7 readout long");

        // R10: abort during internal conversion, same cycle as a tick
        vin = 14'h3C3C;
        send_start(1'b1, 1'b1, 1'b0);
        int_acq(1'b0);
        for (int t = 0; t < 5; t++) tick();
        @(negedge clk) begin abort = 1'b1; osc_tick = 1'b1; end
        @(negedge clk) begin abort = 1'b0; osc_tick = 1'b0; end
        check_eq("R10 strobe idle int", int'(strobe), 1);
        check_eq("R10 sample", int'(sample), 0);
        check_eq("R10 dac", int'(dac_code), 0);
        for (int t = 0; t < RES; t++) tick();
        check_eq("R10 strobe after ticks", int'(strobe), 1);
        for (int i = 0; i < 4; i++) do_fall(1'b0, "R10 no result");

        // R10: shutdown during external conversion
        vin = 14'h2AAA;
        send_start(1'b1, 1'b0, 1'b0);
        ext_falls(1'b1, 1'b0, 1, 9);
        @(negedge clk) shdn_n = 1'b0;
        @(negedge clk) shdn_n = 1'b1;
        check_eq("R10 strobe idle ext", int'(strobe), 0);
        check_eq("R10 dout shdn", int'(dout), 0);
        check_eq("R10 dac shdn", int'(dac_code), 0);
        for (int i = 0; i < 6; i++) do_fall(1'b0, "R10 no result ext");

        // R11: restart during acquisition
        vin = 14'h0555;
        send_start(1'b1, 1'b0, 1'b0);
        ext_falls(1'b1, 1'b0, 1, 3);
        vin = 14'h3AB1;
        send_start(1'b0, 1'b0, 1'b0);
        ext_falls(1'b0, 1'b0, 1, 24);
        check_eq("R11 restart idle", int'(sample), 0);

        repeat (3) @(negedge clk);
        check_eq("R6 queue drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule